// File: doc/BRIEF.md
# NMI Detection and Masking Controller

This block watches an asynchronous non-maskable interrupt pin and decides when a request from it reaches the CPU. The pin goes through a two-flop synchronizer. An edge detector, set to falling or rising edge, records each request in a sticky pending latch. The latch holds the request until the CPU acknowledges it. A block input from the CPU can hold the request back. A block-mode control bit lets the request through anyway, and that bit clears itself when the CPU takes the request.

The block also drives a global mask for all other interrupt sources. This mask is active while the synchronized pin is low and either the mask-while-low control is set or the chip is in standby. In standby with the pin low, the NMI request itself is also held back, so standby does not end. A 16-bit control port holds the edge, block-mode and mask-while-low settings, and a read-only copy of the synchronized pin level.

Top module: `nmi_gate`

## Requirements
- R1: Bit 15 of `regRdData` reads the synchronized pin level (1 = high). Writes to bit 15 do not change it. A pin change shows on this bit two clock edges after it is applied.
- R2: `regRdData` bits 13:10 and 7:0 always read 0. The writable bits are mask-while-low (bit 14), block mode (bit 9) and edge select (bit 8), and all three reset to 0.
- R3: When bit 8 is 0, only a falling edge on the synchronized pin raises a request. When bit 8 is 1, only a rising edge does. Changing bit 8 while the pin is steady raises no request.
- R4: A detected edge sets a pending request. The request stays presented until a cycle in which `nmiAck` is high while `nmiReq` is high, and that cycle clears it.
- R5: While `cpuBlock` is 1 and bit 9 is 0, a pending request is held with `nmiReq` low. It appears on `nmiReq` in the same cycle that `cpuBlock` returns to 0.
- R6: While bit 9 is 1, a pending request drives `nmiReq` high even though `cpuBlock` is 1.
- R7: Accepting a request clears bit 9. Acceptance means `nmiAck` and `nmiReq` are both high on a clock edge.
- R8: When bit 14 is 1 and the synchronized pin is low, `maskAll` is 1. When bit 14 is 0 and `standby` is 0, `maskAll` stays 0. Outside standby, an NMI request is still presented while `maskAll` is 1.
- R9: While `standby` is 1 and the synchronized pin is low, `maskAll` is 1 and `nmiReq` is 0. A request latched during that time is presented once the pin reads high.
- R10: A pin edge applied before a clock edge produces `nmiReq` high after the third clock edge, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| nmiPin | input | 1 | Asynchronous NMI pin |
| cpuBlock | input | 1 | CPU block flag |
| standby | input | 1 | Chip is in standby |
| nmiAck | input | 1 | CPU takes the presented NMI |
| regWrEn | input | 1 | Write strobe for the control register |
| regWrData | input | 16 | Write data |
| regRdData | output | 16 | Control register and pin level read-back |
| nmiReq | output | 1 | NMI request to the CPU |
| maskAll | output | 1 | Mask for all other interrupt requests |

## Verification
A wrong pending latch shows on `nmiReq` at once. A lost edge keeps `nmiReq` low on the third edge after the pin moves. A stuck latch keeps `nmiReq` high one edge after acknowledge. A wrong edge history or edge select raises or drops a request within three edges of a pin change or a register write. A wrong block-mode state shows in bit 9 of the read-back one cycle after acceptance, and as a held or leaked `nmiReq` while `cpuBlock` is high. Masking faults show on `maskAll` two edges after the pin falls or rises.

// File: rtl/nmi_pkg.sv
package nmi_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic clrBlockMode;   // hardware clear of the block-mode bit on acceptance
  } ctlStrobe_t;

  // State reported by the datapath to control
  typedef struct packed {
    logic edgeSeen;       // qualified edge on the synchronized pin this cycle
    logic pinLevel;       // synchronized pin level
    logic blockMode;      // block-mode control bit
    logic maskLow;        // mask-while-low control bit
  } dpStatus_t;

endpackage

// File: rtl/nmi_datapath.sv
module nmi_datapath
  import nmi_pkg::*;
#(
  parameter int   REG_W       = 16,
  parameter int   SYNC_STAGES = 2,
  parameter int   PIN_BIT     = 15,
  parameter int   MASK_BIT    = 14,
  parameter int   BLOCK_BIT   = 9,
  parameter int   EDGE_BIT    = 8,
  parameter logic IDLE_LEVEL  = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             nmiPin,
  input  logic             regWrEn,
  input  logic [REG_W-1:0] regWrData,
  input  ctlStrobe_t       strobe,
  output logic [REG_W-1:0] regRdData,
  output dpStatus_t        status
);

  localparam logic [REG_W-1:0] WR_MASK =
      (REG_W'(1) << MASK_BIT) | (REG_W'(1) << BLOCK_BIT) | (REG_W'(1) << EDGE_BIT);

  logic [SYNC_STAGES-1:0] syncChain;
  logic                   pinSync;
  logic                   prevSample;
  logic [REG_W-1:0]       ctrlQ;
  logic [REG_W-1:0]       ctrlNext;
  logic                   edgeSel;
  logic                   riseSeen;
  logic                   fallSeen;

  // Synchronizer chain, first stage fed by the pin
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncChain[0] <= IDLE_LEVEL;
    else       syncChain[0] <= nmiPin;
  end

  generate
    for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncChain[s] <= IDLE_LEVEL;
        else       syncChain[s] <= syncChain[s-1];
      end
    end
  endgenerate

  assign pinSync = syncChain[SYNC_STAGES-1];

  // Edge history: reloaded with the current sample every cycle, which covers
  // the edge-select change case (history always equals the last sample)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevSample <= IDLE_LEVEL;
    else       prevSample <= pinSync;
  end

  assign edgeSel  = ctrlQ[EDGE_BIT];
  assign riseSeen = pinSync & ~prevSample;
  assign fallSeen = ~pinSync & prevSample;

  // Control register update; hardware clear of block mode wins over a write
  always_comb begin
    ctrlNext = ctrlQ;
    if (regWrEn) ctrlNext = regWrData & WR_MASK;
    if (strobe.clrBlockMode) ctrlNext[BLOCK_BIT] = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ctrlQ <= '0;
    else       ctrlQ <= ctrlNext;
  end

  always_comb begin
    regRdData          = ctrlQ;
    regRdData[PIN_BIT] = pinSync;
  end

  assign status.edgeSeen  = edgeSel ? riseSeen : fallSeen;
  assign status.pinLevel  = pinSync;
  assign status.blockMode = ctrlQ[BLOCK_BIT];
  assign status.maskLow   = ctrlQ[MASK_BIT];

endmodule

// File: rtl/nmi_control.sv
module nmi_control
  import nmi_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cpuBlock,
  input  logic       standby,
  input  logic       nmiAck,
  input  dpStatus_t  status,
  output ctlStrobe_t strobe,
  output logic       nmiReq,
  output logic       maskAll
);

  logic pendingQ;
  logic pinLow;
  logic standbyHold;
  logic blockHold;
  logic present;
  logic accept;

  assign pinLow      = ~status.pinLevel;
  assign standbyHold = standby & pinLow;
  assign blockHold   = cpuBlock & ~status.blockMode;
  assign present     = pendingQ & ~blockHold & ~standbyHold;
  assign accept      = present & nmiAck;

  // A new edge in the acceptance cycle keeps the request pending
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                pendingQ <= 1'b0;
    else if (status.edgeSeen) pendingQ <= 1'b1;
    else if (accept)          pendingQ <= 1'b0;
  end

  assign strobe.clrBlockMode = accept;
  assign nmiReq              = present;
  assign maskAll             = pinLow & (status.maskLow | standby);

endmodule

// File: rtl/nmi_gate.sv
module nmi_gate
  import nmi_pkg::*;
#(
  parameter int REG_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             nmiPin,
  input  logic             cpuBlock,
  input  logic             standby,
  input  logic             nmiAck,
  input  logic             regWrEn,
  input  logic [REG_W-1:0] regWrData,
  output logic [REG_W-1:0] regRdData,
  output logic             nmiReq,
  output logic             maskAll
);

  ctlStrobe_t strobe;
  dpStatus_t  status;

  nmi_datapath #(
    .REG_W      (REG_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .nmiPin   (nmiPin),
    .regWrEn  (regWrEn),
    .regWrData(regWrData),
    .strobe   (strobe),
    .regRdData(regRdData),
    .status   (status)
  );

  nmi_control u_ctl (
    .clk     (clk),
    .rstN    (rstN),
    .cpuBlock(cpuBlock),
    .standby (standby),
    .nmiAck  (nmiAck),
    .status  (status),
    .strobe  (strobe),
    .nmiReq  (nmiReq),
    .maskAll (maskAll)
  );

endmodule

// File: rtl/nmi_gate_checker.sv
module nmi_gate_checker (
  input logic        clk,
  input logic        rstN,
  input logic        cpuBlock,
  input logic        standby,
  input logic        nmiAck,
  input logic [15:0] regRdData,
  input logic        nmiReq,
  input logic        maskAll
);

  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (regRdData & 16'h3CFF) == 16'h0000);  // R2

  AST_BLOCK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (nmiReq && cpuBlock) |-> regRdData[9]);  // R5

  AST_BLOCKMODE_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (nmiAck && nmiReq) |=> !regRdData[9]);  // R7

  AST_STANDBY_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (standby && !regRdData[15]) |-> (!nmiReq && maskAll));  // R9

  AST_MASK_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (regRdData[14] && !regRdData[15]) |-> maskAll);  // R8

  AST_PENDING_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (!cpuBlock && !standby && $past(nmiReq && !nmiAck)) |-> nmiReq);  // R4

endmodule

bind nmi_gate nmi_gate_checker u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .cpuBlock (cpuBlock),
  .standby  (standby),
  .nmiAck   (nmiAck),
  .regRdData(regRdData),
  .nmiReq   (nmiReq),
  .maskAll  (maskAll)
);

// File: tb/tb_nmi_gate.sv
module tb_nmi_gate;

  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        nmiPin = 1'b1;
  logic        cpuBlock = 1'b0;
  logic        standby = 1'b0;
  logic        nmiAck = 1'b0;
  logic        regWrEn = 1'b0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic        nmiReq;
  logic        maskAll;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nmi_gate dut (
    .clk      (clk),
    .rstN     (rstN),
    .nmiPin   (nmiPin),
    .cpuBlock (cpuBlock),
    .standby  (standby),
    .nmiAck   (nmiAck),
    .regWrEn  (regWrEn),
    .regWrData(regWrData),
    .regRdData(regRdData),
    .nmiReq   (nmiReq),
    .maskAll  (maskAll)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic waitEdges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic writeReg(input logic [15:0] d);
    regWrEn = 1'b1; regWrData = d;
    waitEdges(1);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic ackPulse();
    nmiAck = 1'b1;
    waitEdges(1);
    nmiAck = 1'b0;
  endtask

  task automatic testReset();
    check("R2 reset readback", regRdData, 16'h8000);
    check("R4 reset nmiReq", {15'd0, nmiReq}, 16'd0);
    check("R8 reset maskAll", {15'd0, maskAll}, 16'd0);
  endtask

  task automatic testFalling();
    nmiPin = 1'b0;
    waitEdges(2);
    check("R10 no request before third edge", {15'd0, nmiReq}, 16'd0);
    check("R1 pin level low", {15'd0, regRdData[15]}, 16'd0);
    waitEdges(1);
    check("R3 R10 falling edge request", {15'd0, nmiReq}, 16'd1);
    waitEdges(3);
    check("R4 request sticky", {15'd0, nmiReq}, 16'd1);
    ackPulse();
    check("R4 ack clears", {15'd0, nmiReq}, 16'd0);
    nmiPin = 1'b1;
    waitEdges(4);
    check("R3 rising ignored in falling mode", {15'd0, nmiReq}, 16'd0);
    check("R1 pin level high", {15'd0, regRdData[15]}, 16'd1);
  endtask

  task automatic testRising();
    writeReg(16'h0100);
    waitEdges(3);
    check("R3 edge select change no false edge", {15'd0, nmiReq}, 16'd0);
    check("R2 edge select readback", regRdData, 16'h8100);
    nmiPin = 1'b0;
    waitEdges(4);
    check("R3 falling ignored in rising mode", {15'd0, nmiReq}, 16'd0);
    writeReg(16'h0000);
    waitEdges(3);
    check("R3 select change while low no false edge", {15'd0, nmiReq}, 16'd0);
    writeReg(16'h0100);
    nmiPin = 1'b1;
    waitEdges(3);
    check("R3 rising edge request", {15'd0, nmiReq}, 16'd1);
    ackPulse();
    writeReg(16'h0000);
  endtask

  task automatic testBlockHold();
    cpuBlock = 1'b1;
    nmiPin = 1'b0;
    waitEdges(5);
    check("R5 held while blocked", {15'd0, nmiReq}, 16'd0);
    cpuBlock = 1'b0;
    #1;
    check("R5 released when block drops", {15'd0, nmiReq}, 16'd1);
    waitEdges(1);
    ackPulse();
    check("R4 ack after release", {15'd0, nmiReq}, 16'd0);
    nmiPin = 1'b1;
    waitEdges(3);
  endtask

  task automatic testBlockMode();
    writeReg(16'h0200);
    check("R6 block mode readback", {15'd0, regRdData[9]}, 16'd1);
    cpuBlock = 1'b1;
    nmiPin = 1'b0;
    waitEdges(3);
    check("R6 delivered while blocked", {15'd0, nmiReq}, 16'd1);
    ackPulse();
    check("R7 block mode self-clears", {15'd0, regRdData[9]}, 16'd0);
    check("R7 request cleared", {15'd0, nmiReq}, 16'd0);
    cpuBlock = 1'b0;
    nmiPin = 1'b1;
    waitEdges(3);
  endtask

  task automatic testMaskLow();
    nmiPin = 1'b0;
    waitEdges(3);
    check("R8 no mask when option off", {15'd0, maskAll}, 16'd0);
    ackPulse();
    nmiPin = 1'b1;
    waitEdges(3);
    writeReg(16'h4000);
    check("R8 mask off while pin high", {15'd0, maskAll}, 16'd0);
    nmiPin = 1'b0;
    waitEdges(2);
    check("R8 mask while low", {15'd0, maskAll}, 16'd1);
    waitEdges(1);
    check("R8 NMI still presented", {15'd0, nmiReq}, 16'd1);
    ackPulse();
    nmiPin = 1'b1;
    waitEdges(2);
    check("R8 mask drops with pin high", {15'd0, maskAll}, 16'd0);
    writeReg(16'h0000);
  endtask

  task automatic testStandby();
    standby = 1'b1;
    nmiPin = 1'b0;
    waitEdges(4);
    check("R9 standby mask while low", {15'd0, maskAll}, 16'd1);
    check("R9 standby request held", {15'd0, nmiReq}, 16'd0);
    nmiPin = 1'b1;
    waitEdges(2);
    check("R9 request after pin high", {15'd0, nmiReq}, 16'd1);
    check("R9 mask released", {15'd0, maskAll}, 16'd0);
    ackPulse();
    standby = 1'b0;
  endtask

  task automatic testReadOnly();
    writeReg(16'h0000);
    check("R1 write cannot clear pin bit", {15'd0, regRdData[15]}, 16'd1);
    writeReg(16'hFFFF);
    check("R2 reserved bits stay zero", regRdData, 16'hC300);
    writeReg(16'h0000);
    nmiPin = 1'b0;
    waitEdges(3);
    ackPulse();
    writeReg(16'h8000);
    check("R1 write cannot set pin bit", regRdData, 16'h0000);
    nmiPin = 1'b1;
    waitEdges(3);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    waitEdges(3);
    rstN = 1'b1;
    waitEdges(3);
    testReset();
    testFalling();
    testRising();
    testBlockHold();
    testBlockMode();
    testMaskLow();
    testStandby();
    testReadOnly();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule